// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a watchdog counter that is armed and counting as soon as power-on reset is released. It counts up from a programmable reload value. When it passes the all-ones value it raises a reset request for one cycle, reloads and keeps counting. Software controls it through a flat register port with a combinational read path and single-cycle writes.

Software can stop the counter only by writing two key words, in the right order, to a run-control register. Each write to that register takes a fixed number of cycles to take effect. While a write is in flight a pending flag is set, and software polls this flag before sending the next key. A separate key pair starts a stopped counter again.

A soft-reset control returns the whole block to its power-on state for a fixed number of cycles, and a done flag reports when that reset has finished. The soft reset always re-arms the watchdog, even if software had stopped it.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the counter starts at the default reload value 0xFFFF0000 and increases by one every cycle. The reload register (offset 0x2C) reads 0xFFFF0000.
- R2: When the running counter holds 0xFFFFFFFF, the next clock edge sets `wdt_rst_req` high for exactly that one cycle and loads the counter from the reload register. With reload value L the request therefore repeats every 2^32 − L cycles.
- R3: The reload register at 0x2C can be read and written. A new value first takes effect at the next reload. The counter value can be read at 0x28.
- R4: The run-control register is at offset 0x48. A committed 0x0000AAAA followed by a committed 0x00005555 stops the counter, which then holds its value and raises no request. A committed 0xAAAA alone leaves the counter running.
- R5: A committed 0x0000BBBB followed by a committed 0x00004444 restarts a stopped counter. The counter holds the reload value in the cycle the second key commits.
- R6: A committed word that breaks the key order cancels the partial sequence. For example, 0xAAAA, then 0x1234, then 0x5555 leaves the counter running.
- R7: A write to 0x48 commits 4 cycles after it is accepted. Bit 4 of the status register at 0x34 reads 1 for exactly those 4 cycles. Reading 0x48 returns the last committed word.
- R8: A write to 0x48 that arrives while bit 4 of 0x34 is set is discarded. It neither changes the committed word nor moves the key sequence.
- R9: Writing 1 to bit 1 of the control register (0x10) starts a soft reset. Bit 0 of 0x14 then reads 0 for 8 cycles and 1 otherwise. The control register always reads 0.
- R10: When a soft reset completes, the counter is running from 0xFFFF0000 and the reload register holds 0xFFFF0000, even if the counter had been stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The assertions assume that the register port behaves as a simple synchronous master. That is, `wr_en`, `addr` and `wdata` are stable around each rising edge, and power-on reset is applied before any checked cycle. The bench meets this by changing inputs only on falling edges and by holding reset for several cycles.

The key-order and pending-window assertions also assume that software may write at any time. The bench therefore deliberately sends one key while a commit is still pending, so that the discard path is exercised rather than avoided.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_COUNT = 8'h28;
  localparam logic [7:0] OFS_LOAD  = 8'h2C;
  localparam logic [7:0] OFS_PEND  = 8'h34;
  localparam logic [7:0] OFS_RUN   = 8'h48;

  localparam logic [WDT_W-1:0] KEY_STOP_A  = 32'h0000_AAAA;
  localparam logic [WDT_W-1:0] KEY_STOP_B  = 32'h0000_5555;
  localparam logic [WDT_W-1:0] KEY_START_A = 32'h0000_BBBB;
  localparam logic [WDT_W-1:0] KEY_START_B = 32'h0000_4444;

  typedef enum logic [1:0] {KS_IDLE, KS_STOP1, KS_START1} key_st_e;

  typedef struct packed {
    key_st_e nxt;
    logic    stop;
    logic    start;
  } key_res_t;

  function automatic key_res_t key_step(key_st_e st, logic [WDT_W-1:0] w);
    key_res_t r;
    r.nxt = KS_IDLE;
    r.stop = 1'b0;
    r.start = 1'b0;
    if (w == KEY_STOP_A)
      r.nxt = KS_STOP1;
    else if (w == KEY_START_A)
      r.nxt = KS_START1;
    else if (w == KEY_STOP_B && st == KS_STOP1)
      r.stop = 1'b1;
    else if (w == KEY_START_B && st == KS_START1)
      r.start = 1'b1;
    return r;
  endfunction

  // {carry, incremented value}
  function automatic logic [WDT_W:0] cnt_step(logic [WDT_W-1:0] c);
    return {1'b0, c} + {{WDT_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int COMMIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [WDT_W-1:0] data_i,
  output logic             pending_o,
  output logic             enabled_o,
  output logic             start_evt_o,
  output logic [WDT_W-1:0] shown_o
);
  localparam int CW = $clog2(COMMIT_CYC + 1);
  localparam logic [CW-1:0] CYC_V = CW'(COMMIT_CYC);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic [CW-1:0]    cnt_q;
  logic [WDT_W-1:0] stage_q;
  logic [WDT_W-1:0] shown_q;
  key_st_e          state_q;
  logic             en_q;
  logic             accept;
  logic             commit;
  key_res_t         kr;

  assign accept = wr_i && (cnt_q == '0);
  assign commit = (cnt_q == ONE_V);
  assign kr     = key_step(state_q, stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stage_q <= '0;
      shown_q <= '0;
      state_q <= KS_IDLE;
      en_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      stage_q <= '0;
      shown_q <= '0;
      state_q <= KS_IDLE;
      en_q <= 1'b1;
    end else begin
      if (accept) begin
        cnt_q <= CYC_V;
        stage_q <= data_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - ONE_V;
      end
      if (commit) begin
        state_q <= kr.nxt;
        shown_q <= stage_q;
        if (kr.stop) en_q <= 1'b0;
        if (kr.start) en_q <= 1'b1;
      end
    end
  end

  assign pending_o   = (cnt_q != '0);
  assign enabled_o   = en_q;
  assign start_evt_o = commit && kr.start;
  assign shown_o     = shown_q;

  // R8
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (wr_i && pending_o) |=> $stable(stage_q));
  // R4
  stop_needs_order_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    $fell(en_q) |-> $past(state_q == KS_STOP1 && commit));
  // R7
  pend_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    $rose(pending_o) |-> $past(wr_i));
  // R7
  pend_ends_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    commit |=> !pending_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter logic [WDT_W-1:0] LOAD_DEF = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [WDT_W-1:0] load_i,
  output logic [WDT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [WDT_W-1:0] cnt_q;
  logic             exp_q;
  logic [WDT_W:0]   step;
  logic             wrap_evt;

  assign step     = cnt_step(cnt_q);
  assign wrap_evt = run_i && !start_i && step[WDT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD_DEF;
      exp_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= LOAD_DEF;
      exp_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load_i;
      exp_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= wrap_evt ? load_i : step[WDT_W-1:0];
      exp_q <= wrap_evt;
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;

  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (run_i && !start_i && cnt_q == '1) |=> (exp_q && cnt_q == $past(load_i)));
  // R2
  pulse_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    $rose(exp_q) |-> $past(cnt_q == '1));
  // R4
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (!run_i && !start_i) |=> ($stable(cnt_q) && !exp_q));
endmodule

// File: rtl/wdt_srst.sv
module wdt_srst #(
  parameter int SRST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int SW = $clog2(SRST_CYC + 1);
  localparam logic [SW-1:0] LEN_V = SW'(SRST_CYC);
  localparam logic [SW-1:0] ONE_V = SW'(1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else if (left_q != '0) left_q <= left_q - ONE_V;
    else if (start_i) left_q <= LEN_V;
  end

  assign busy_o = (left_q != '0);
  assign done_o = !busy_o;

  // R9
  srst_started_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R9
  srst_finishes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == ONE_V) |=> done_o);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int               COMMIT_CYC = 4,
  parameter int               SRST_CYC   = 8,
  parameter logic [WDT_W-1:0] LOAD_DEF   = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [WDT_W-1:0] wdata,
  output logic [WDT_W-1:0] rdata,
  output logic             wdt_rst_req
);
  logic             srst_busy;
  logic             srst_done;
  logic             wr_ok;
  logic             run_wr;
  logic             srst_go;
  logic             pending;
  logic             enabled;
  logic             start_evt;
  logic [WDT_W-1:0] shown;
  logic [WDT_W-1:0] load_q;
  logic [WDT_W-1:0] cnt;

  assign wr_ok   = wr_en && !srst_busy;
  assign run_wr  = wr_ok && (addr == OFS_RUN);
  assign srst_go = wr_ok && (addr == OFS_CTRL) && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= LOAD_DEF;
    else if (srst_busy) load_q <= LOAD_DEF;
    else if (wr_ok && addr == OFS_LOAD) load_q <= wdata;
  end

  wdt_srst #(.SRST_CYC(SRST_CYC)) u_srst (
    .clk(clk), .rst_n(rst_n), .start_i(srst_go),
    .busy_o(srst_busy), .done_o(srst_done)
  );

  wdt_key_seq #(.COMMIT_CYC(COMMIT_CYC)) u_keys (
    .clk(clk), .rst_n(rst_n), .clr_i(srst_busy), .wr_i(run_wr),
    .data_i(wdata), .pending_o(pending), .enabled_o(enabled),
    .start_evt_o(start_evt), .shown_o(shown)
  );

  wdt_counter #(.LOAD_DEF(LOAD_DEF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(srst_busy), .run_i(enabled),
    .start_i(start_evt), .load_i(load_q), .cnt_o(cnt), .expire_o(wdt_rst_req)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_STAT:  rdata = {{(WDT_W-1){1'b0}}, srst_done};
      OFS_COUNT: rdata = cnt;
      OFS_LOAD:  rdata = load_q;
      OFS_PEND:  rdata = {{(WDT_W-5){1'b0}}, pending, 4'b0000};
      OFS_RUN:   rdata = shown;
      default:   rdata = '0;
    endcase
  end

  // R10
  rearm_after_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy) |-> (enabled && load_q == LOAD_DEF && cnt == LOAD_DEF));
  // R9
  no_write_in_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> !pending);
endmodule

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst_req;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdt_keyed_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_pend(output int n);
    logic [31:0] v;
    n = 0;
    rd(8'h34, v);
    while (v[4] && n < 100) begin
      n++;
      @(negedge clk);
      rd(8'h34, v);
    end
  endtask

  task automatic wait_pulse(output longint n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_rst_req && n < 150000);
  endtask

  task automatic key(input logic [31:0] d);
    int n;
    wr(8'h48, d);
    wait_pend(n);
  endtask

  task automatic probe_run(output bit moving, output int pulses);
    logic [31:0] c1, c2;
    pulses = 0;
    rd(8'h28, c1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wdt_rst_req) pulses++;
    end
    rd(8'h28, c2);
    moving = (c1 != c2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c, c2;
    longint n, m;
    int pn, pulses;
    bit moving;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h2C, v);
    chk(v == 32'hFFFF0000, "R1 load default", v, 32'hFFFF0000);
    rd(8'h14, v);
    chk(v == 32'h1, "R9 done after reset", v, 1);
    rd(8'h34, v);
    chk(v == 32'h0, "R7 no pending at reset", v, 0);
    rd(8'h28, c);
    chk(c >= 32'hFFFF0000 && c < 32'hFFFF0010, "R1 count near default", c, 32'hFFFF0000);
    wr(8'h2C, 32'hFFFFFFF0);
    rd(8'h28, c2);
    chk(c2 == c + 2, "R1 counts each cycle", c2, c + 2);
    rd(8'h2C, v);
    chk(v == 32'hFFFFFFF0, "R3 load readback", v, 32'hFFFFFFF0);
    // R2 first expiry from default count
    wait_pulse(n);
    chk(n == 64'h1_0000_0000 - c2, "R2 first expiry time", n, 64'h1_0000_0000 - c2);
    rd(8'h28, v);
    chk(v == 32'hFFFFFFF0, "R3 new load used at reload", v, 32'hFFFFFFF0);

    // R2 / R3 period sweep
    for (int k = 0; k < 20; k++) begin
      logic [31:0] lv;
      lv = (k < 16) ? (32'hFFFFFFFF - k) : (32'hFFFFFFFF - 32'(k * 13));
      wr(8'h2C, lv);
      wait_pulse(m);
      wait_pulse(m);
      wait_pulse(m);
      chk(m == 64'h1_0000_0000 - lv, "R2 period", m, 64'h1_0000_0000 - lv);
    end

    wr(8'h2C, 32'hFFFFFF00);
    wait_pulse(m);

    // R7 pending window and R6 broken order
    wr(8'h48, 32'h0000AAAA);
    wait_pend(pn);
    chk(pn == 4, "R7 pending cycles", pn, 4);
    rd(8'h48, v);
    chk(v == 32'h0000AAAA, "R7 committed readback", v, 32'hAAAA);
    probe_run(moving, pulses);
    chk(moving, "R4 first key alone keeps counting", moving, 1);
    key(32'h00001234);
    key(32'h00005555);
    probe_run(moving, pulses);
    chk(moving, "R6 broken order still counting", moving, 1);

    // R8 write during pending is discarded
    wr(8'h48, 32'h0000AAAA);
    wr(8'h48, 32'h00005555);
    wait_pend(pn);
    rd(8'h48, v);
    chk(v == 32'h0000AAAA, "R8 busy write discarded", v, 32'hAAAA);
    probe_run(moving, pulses);
    chk(moving, "R8 still counting", moving, 1);

    // R4 stop with proper second key
    wr(8'h2C, 32'hFFFFFFF0);
    wait_pulse(m);
    key(32'h00005555);
    probe_run(moving, pulses);
    chk(!moving, "R4 stopped count holds", moving, 0);
    chk(pulses == 0, "R4 no request when stopped", pulses, 0);

    // R5 restart
    key(32'h0000BBBB);
    wr(8'h48, 32'h00004444);
    wait_pend(pn);
    rd(8'h28, v);
    chk(v == 32'hFFFFFFF0, "R5 restart from load", v, 32'hFFFFFFF0);
    @(negedge clk);
    rd(8'h28, v);
    chk(v == 32'hFFFFFFF1, "R5 counting after restart", v, 32'hFFFFFFF1);

    // R10 soft reset while stopped
    key(32'h0000AAAA);
    key(32'h00005555);
    probe_run(moving, pulses);
    chk(!moving, "R4 stopped before soft reset", moving, 0);
    wr(8'h10, 32'h00000002);
    pn = 0;
    rd(8'h14, v);
    while (v[0] == 1'b0 && pn < 100) begin
      pn++;
      @(negedge clk);
      rd(8'h14, v);
    end
    chk(pn == 8, "R9 done low cycles", pn, 8);
    rd(8'h28, c);
    chk(c == 32'hFFFF0000, "R10 count at default after soft reset", c, 32'hFFFF0000);
    rd(8'h2C, v);
    chk(v == 32'hFFFF0000, "R10 load default after soft reset", v, 32'hFFFF0000);
    rd(8'h10, v);
    chk(v == 32'h0, "R9 control reads zero", v, 0);
    @(negedge clk);
    rd(8'h28, c);
    chk(c == 32'hFFFF0001, "R10 re-armed counting", c, 32'hFFFF0001);
    rd(8'h48, v);
    chk(v == 32'h0, "R10 run register cleared", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule